// File: doc/BRIEF.md
# Indirect Configuration Value Router

This block sits on the register side of a multi-group sampling front end. Software cannot reach each tuning parameter directly. It loads one 32-bit value word, two one-hot masks and a control word. The group mask picks converter groups and the channel mask picks channels inside each group. The control word carries a 3-bit type code that names the target parameter. Setting the update bit in the control word starts a transfer. The router copies the value word into every selected target. A group that is busy converting is skipped until it goes idle. Once every selected group has taken the value, hardware clears the update bit, and software polls for that as its acknowledgment.

The same control word holds three more things: the sampling mode bits, a self-clearing software trigger for the selected groups, and a software reset. The router sends the parameters out as flat vectors, one slice per group or per group and channel, ready for the datapath to use. The flow here is register writes, not a stream, so every pin is plain and none has a handshake. A write that lands while an update is still pending is dropped as an update request, and software is expected to poll first.

Top module: `cvr_router`

## Requirements
- R1: After reset the control readback is 0, every offset is 0, every conversion factor equals FAC_RST, every samples value equals SMP_RST, every sample time is 0, and no trigger request is active.
- R2: Type code 000 in control bits 7..5 writes cfg_value[OFS_W-1:0] into the offset of every channel whose ch_sel bit is set, in every group whose grp_sel bit is set. All other offsets are left unchanged.
- R3: Type code 001 writes cfg_value[FAC_W-1:0] into the conversion factor of every selected channel of every selected group. All other factors are left unchanged.
- R4: Type code 010 writes the samples value and type code 011 writes the sample time of each selected group. The channel mask has no effect on either, and neither touches any offset or factor.
- R5: A write with control bit 4 set captures the value, type and masks on the clock edge that samples it. A selected group that is idle at the next edge is updated on that edge. A selected group that is busy is updated on the first edge at which it is idle.
- R6: Readback bit 4 is 1 while any selected group is still waiting and drops to 0 after the last one is updated. If no group in range is selected, it reads 0 right after the write. Mask bits at or above G (groups) or CH (channels) are ignored.
- R7: Type codes 100 to 111 are acknowledged in the same way but change no parameter.
- R8: An update request that arrives while a previous update is still pending is dropped. The pending transfer keeps its original value, type and masks.
- R9: Control bit 2 raises trig_req for every group selected in grp_sel. Each group's request stays high until grp_started is seen for that group. Readback bit 2 is 1 while any request is still high.
- R10: A control write with bit 3 set ignores all other bits of that write. On the following edge it returns every register and output to its R1 state. Readback bit 3 always reads 0.
- R11: A control write without bit 3 stores bit 0 on cont_mode (1 = continuous, 0 = triggered), bit 1 on sw_trig_src (1 = software trigger source in triggered mode) and bits 7..5 as the type code. All three are readable at the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | One-cycle strobe that writes the control word |
| ctl_wdata | input | 32 | Control word being written |
| grp_sel | input | 32 | One-hot group mask |
| ch_sel | input | 32 | One-hot channel mask |
| cfg_value | input | 32 | Value word to deliver |
| grp_busy | input | G | Per-group busy flags from the datapath |
| grp_started | input | G | Per-group conversion-started flags from the datapath |
| ctl_rdata | output | 32 | Control word readback |
| cont_mode | output | 1 | Continuous mode selected |
| sw_trig_src | output | 1 | Software trigger source selected |
| trig_req | output | G | Pending software trigger per group |
| offset_o | output | G*CH*OFS_W | Offsets, group-major, channel-minor |
| factor_o | output | G*CH*FAC_W | Conversion factors, group-major, channel-minor |
| samples_o | output | G*SMP_W | Samples per trigger, one slice per group |
| stime_o | output | G*STM_W | Sample time, one slice per group |

## Verification
The assertions place no limit on how long grp_busy stays high. They assume ctl_wr is a one-cycle strobe and that grp_started pulses only for a group whose request is live. The stimulus follows both rules. It holds group 1 busy for several cycles while a second request is issued, to exercise deferral and the drop rule. It also drives out-of-range mask bits, a reserved type code, and a reset word that sets other bits too. A behavioural model in the bench, built on plain arrays, is compared with every output on each falling edge.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
  localparam int CW          = 32;
  localparam int BIT_MODE    = 0;
  localparam int BIT_SRC     = 1;
  localparam int BIT_TRIG    = 2;
  localparam int BIT_SRST    = 3;
  localparam int BIT_UPD     = 4;
  localparam int BIT_TYPE_LO = 5;
  localparam int TW          = 3;

  localparam logic [TW-1:0] TGT_OFS = 3'd0;
  localparam logic [TW-1:0] TGT_FAC = 3'd1;
  localparam logic [TW-1:0] TGT_SMP = 3'd2;
  localparam logic [TW-1:0] TGT_STM = 3'd3;
endpackage

// File: rtl/cvr_ctl_word.sv
module cvr_ctl_word
  import cvr_pkg::*;
#(
  parameter int G = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_i,
  input  logic          ctl_wr,
  input  logic [CW-1:0] ctl_wdata,
  input  logic [CW-1:0] grp_sel,
  input  logic [G-1:0]  grp_started,
  input  logic          upd_busy,
  output logic          srst_q,
  output logic          cont_mode,
  output logic          sw_src,
  output logic [TW-1:0] tf_q,
  output logic [G-1:0]  trig_q,
  output logic [CW-1:0] rdata
);
  logic take;
  assign take = ctl_wr & ~ctl_wdata[BIT_SRST];

  always_ff @(posedge clk) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= ctl_wr & ctl_wdata[BIT_SRST];
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cont_mode <= 1'b0;
      sw_src    <= 1'b0;
      tf_q      <= '0;
      trig_q    <= '0;
    end else begin
      trig_q <= (trig_q & ~grp_started)
              | ({G{take & ctl_wdata[BIT_TRIG]}} & grp_sel[G-1:0]);
      if (take) begin
        cont_mode <= ctl_wdata[BIT_MODE];
        sw_src    <= ctl_wdata[BIT_SRC];
        tf_q      <= ctl_wdata[BIT_TYPE_LO +: TW];
      end
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[BIT_MODE]         = cont_mode;
    rdata[BIT_SRC]          = sw_src;
    rdata[BIT_TRIG]         = |trig_q;
    rdata[BIT_UPD]          = upd_busy;
    rdata[BIT_TYPE_LO +: TW] = tf_q;
  end

  // R9
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    1'b1 |=> ((trig_q & $past(trig_q & ~grp_started)) == $past(trig_q & ~grp_started)));
endmodule

// File: rtl/cvr_upd_seq.sv
module cvr_upd_seq
  import cvr_pkg::*;
#(
  parameter int G  = 2,
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          ctl_wr,
  input  logic [CW-1:0] ctl_wdata,
  input  logic [CW-1:0] grp_sel,
  input  logic [CW-1:0] ch_sel,
  input  logic [CW-1:0] cfg_value,
  input  logic [G-1:0]  grp_busy,
  output logic [G-1:0]  pend_q,
  output logic [G-1:0]  wr_en,
  output logic [CW-1:0] val_q,
  output logic [TW-1:0] ut_q,
  output logic [CH-1:0] ch_q
);
  logic accept;
  assign accept = ctl_wr & ctl_wdata[BIT_UPD] & ~ctl_wdata[BIT_SRST] & ~(|pend_q);
  assign wr_en  = pend_q & ~grp_busy;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      pend_q <= '0;
      val_q  <= '0;
      ut_q   <= '0;
      ch_q   <= '0;
    end else if (accept) begin
      pend_q <= grp_sel[G-1:0];
      val_q  <= cfg_value;
      ut_q   <= ctl_wdata[BIT_TYPE_LO +: TW];
      ch_q   <= ch_sel[CH-1:0];
    end else begin
      pend_q <= pend_q & grp_busy;
    end
  end

  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst_i)
    1'b1 |=> ((pend_q & $past(pend_q & ~grp_busy)) == '0));
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    1'b1 |=> ((pend_q & $past(pend_q & grp_busy)) == $past(pend_q & grp_busy)));
  // R8
  held_snap_chk: assert property (@(posedge clk) disable iff (rst_i)
    (pend_q != '0) |=> ($stable(val_q) && $stable(ut_q) && $stable(ch_q)));
endmodule

// File: rtl/cvr_param_bank.sv
module cvr_param_bank
  import cvr_pkg::*;
#(
  parameter int G       = 2,
  parameter int CH      = 4,
  parameter int OFS_W   = 16,
  parameter int FAC_W   = 18,
  parameter int SMP_W   = 16,
  parameter int STM_W   = 16,
  parameter int FAC_RST = 32,
  parameter int SMP_RST = 1
) (
  input  logic                  clk,
  input  logic                  rst_i,
  input  logic [G-1:0]          wr_en,
  input  logic [CW-1:0]         val,
  input  logic [TW-1:0]         ut,
  input  logic [CH-1:0]         ch,
  output logic [G*CH*OFS_W-1:0] offset_o,
  output logic [G*CH*FAC_W-1:0] factor_o,
  output logic [G*SMP_W-1:0]    samples_o,
  output logic [G*STM_W-1:0]    stime_o
);
  for (genvar g = 0; g < G; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst_i) begin
        samples_o[g*SMP_W +: SMP_W] <= SMP_W'(SMP_RST);
        stime_o[g*STM_W +: STM_W]   <= '0;
      end else if (wr_en[g]) begin
        if (ut == TGT_SMP) samples_o[g*SMP_W +: SMP_W] <= val[SMP_W-1:0];
        if (ut == TGT_STM) stime_o[g*STM_W +: STM_W]   <= val[STM_W-1:0];
      end
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
      localparam int IDX = g*CH + c;
      always_ff @(posedge clk) begin
        if (rst_i) begin
          offset_o[IDX*OFS_W +: OFS_W] <= '0;
          factor_o[IDX*FAC_W +: FAC_W] <= FAC_W'(FAC_RST);
        end else if (wr_en[g] && ch[c]) begin
          if (ut == TGT_OFS) offset_o[IDX*OFS_W +: OFS_W] <= val[OFS_W-1:0];
          if (ut == TGT_FAC) factor_o[IDX*FAC_W +: FAC_W] <= val[FAC_W-1:0];
        end
      end
    end
  end

  // R2
  param_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (wr_en == '0) |=> ($stable(offset_o) && $stable(factor_o)
                       && $stable(samples_o) && $stable(stime_o)));
  // R7
  rsv_nochange_chk: assert property (@(posedge clk) disable iff (rst_i)
    ut[2] |=> ($stable(offset_o) && $stable(factor_o)
               && $stable(samples_o) && $stable(stime_o)));
  // R4
  grp_only_chk: assert property (@(posedge clk) disable iff (rst_i)
    ((ut == TGT_SMP) || (ut == TGT_STM)) |=> ($stable(offset_o) && $stable(factor_o)));
endmodule

// File: rtl/cvr_router.sv
module cvr_router
  import cvr_pkg::*;
#(
  parameter int G       = 2,
  parameter int CH      = 4,
  parameter int OFS_W   = 16,
  parameter int FAC_W   = 18,
  parameter int SMP_W   = 16,
  parameter int STM_W   = 16,
  parameter int FAC_RST = 32,
  parameter int SMP_RST = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic [31:0]           ctl_wdata,
  input  logic [31:0]           grp_sel,
  input  logic [31:0]           ch_sel,
  input  logic [31:0]           cfg_value,
  input  logic [G-1:0]          grp_busy,
  input  logic [G-1:0]          grp_started,
  output logic [31:0]           ctl_rdata,
  output logic                  cont_mode,
  output logic                  sw_trig_src,
  output logic [G-1:0]          trig_req,
  output logic [G*CH*OFS_W-1:0] offset_o,
  output logic [G*CH*FAC_W-1:0] factor_o,
  output logic [G*SMP_W-1:0]    samples_o,
  output logic [G*STM_W-1:0]    stime_o
);
  logic          srst_q, rst_i;
  logic [G-1:0]  pend_q, wr_en;
  logic [CW-1:0] val_q;
  logic [TW-1:0] ut_q, tf_q;
  logic [CH-1:0] ch_q;

  assign rst_i = ~rst_n | srst_q;

  cvr_ctl_word #(.G(G)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rst_i(rst_i), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .grp_sel(grp_sel), .grp_started(grp_started),
    .upd_busy(|pend_q), .srst_q(srst_q), .cont_mode(cont_mode),
    .sw_src(sw_trig_src), .tf_q(tf_q), .trig_q(trig_req), .rdata(ctl_rdata)
  );

  cvr_upd_seq #(.G(G), .CH(CH)) u_seq (
    .clk(clk), .rst_i(rst_i), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .grp_sel(grp_sel), .ch_sel(ch_sel), .cfg_value(cfg_value),
    .grp_busy(grp_busy), .pend_q(pend_q), .wr_en(wr_en), .val_q(val_q),
    .ut_q(ut_q), .ch_q(ch_q)
  );

  cvr_param_bank #(
    .G(G), .CH(CH), .OFS_W(OFS_W), .FAC_W(FAC_W), .SMP_W(SMP_W),
    .STM_W(STM_W), .FAC_RST(FAC_RST), .SMP_RST(SMP_RST)
  ) u_bank (
    .clk(clk), .rst_i(rst_i), .wr_en(wr_en), .val(val_q), .ut(ut_q),
    .ch(ch_q), .offset_o(offset_o), .factor_o(factor_o),
    .samples_o(samples_o), .stime_o(stime_o)
  );

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> ((ctl_rdata == '0) && (trig_req == '0) && !cont_mode));
  // R6
  ack_mirror_chk: assert property (@(posedge clk) disable iff (rst_i)
    ($past(ctl_rdata[BIT_UPD]) && (wr_en == pend_q)) |=> !ctl_rdata[BIT_UPD]);
endmodule

// File: tb/test_cvr_router.sv
module test_cvr_router;
  localparam int G = 2, CH = 4, OW = 16, FW = 18, SW = 16, TWD = 16;
  localparam int FRST = 32, SRST = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ctl_wr;
  logic [31:0] ctl_wdata, grp_sel, ch_sel, cfg_value, ctl_rdata;
  logic [G-1:0] grp_busy, grp_started, trig_req;
  logic cont_mode, sw_trig_src;
  logic [G*CH*OW-1:0] offset_o;
  logic [G*CH*FW-1:0] factor_o;
  logic [G*SW-1:0] samples_o;
  logic [G*TWD-1:0] stime_o;

  cvr_router #(.G(G), .CH(CH), .OFS_W(OW), .FAC_W(FW), .SMP_W(SW), .STM_W(TWD),
               .FAC_RST(FRST), .SMP_RST(SRST)) i_cvr_router (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .grp_sel(grp_sel), .ch_sel(ch_sel), .cfg_value(cfg_value),
    .grp_busy(grp_busy), .grp_started(grp_started), .ctl_rdata(ctl_rdata),
    .cont_mode(cont_mode), .sw_trig_src(sw_trig_src), .trig_req(trig_req),
    .offset_o(offset_o), .factor_o(factor_o), .samples_o(samples_o), .stime_o(stime_o));

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0] m_ofs [G][CH];
  logic [31:0] m_fac [G][CH];
  logic [31:0] m_smp [G];
  logic [31:0] m_stm [G];
  logic [G-1:0] m_pend, m_trig;
  logic m_mode, m_src, m_srst = 1'b0;
  logic [2:0] m_tf, m_ut;
  logic [31:0] m_val, m_ch;

  always @(posedge clk) begin : model
    logic [G-1:0] old_pend;
    logic nsr;
    nsr = rst_n && ctl_wr && ctl_wdata[3];
    if (!rst_n || m_srst) begin
      for (int g = 0; g < G; g++) begin
        for (int c = 0; c < CH; c++) begin m_ofs[g][c] = 0; m_fac[g][c] = FRST; end
        m_smp[g] = SRST; m_stm[g] = 0;
      end
      m_pend = 0; m_trig = 0; m_mode = 0; m_src = 0; m_tf = 0; m_ut = 0;
      m_val = 0; m_ch = 0;
    end else begin
      old_pend = m_pend;
      for (int g = 0; g < G; g++) begin
        if (old_pend[g] && !grp_busy[g]) begin
          case (m_ut)
            3'd0: for (int c = 0; c < CH; c++) if (m_ch[c]) m_ofs[g][c] = m_val;
            3'd1: for (int c = 0; c < CH; c++) if (m_ch[c]) m_fac[g][c] = m_val;
            3'd2: m_smp[g] = m_val;
            3'd3: m_stm[g] = m_val;
            default: ;
          endcase
          m_pend[g] = 1'b0;
        end
      end
      m_trig = m_trig & ~grp_started;
      if (ctl_wr && !ctl_wdata[3]) begin
        m_mode = ctl_wdata[0]; m_src = ctl_wdata[1]; m_tf = ctl_wdata[7:5];
        if (ctl_wdata[2]) m_trig = m_trig | grp_sel[G-1:0];
        if (ctl_wdata[4] && old_pend == 0) begin
          m_pend = grp_sel[G-1:0]; m_val = cfg_value; m_ut = ctl_wdata[7:5]; m_ch = ch_sel;
        end
      end
    end
    m_srst = nsr;
  end

  always @(negedge clk) begin : compare
    logic [G*CH*OW-1:0] e_ofs;
    logic [G*CH*FW-1:0] e_fac;
    logic [G*SW-1:0] e_smp;
    logic [G*TWD-1:0] e_stm;
    logic [31:0] e_rd;
    if (cmp_en) begin
      for (int g = 0; g < G; g++) begin
        for (int c = 0; c < CH; c++) begin
          e_ofs[(g*CH+c)*OW +: OW] = m_ofs[g][c][OW-1:0];
          e_fac[(g*CH+c)*FW +: FW] = m_fac[g][c][FW-1:0];
        end
        e_smp[g*SW +: SW] = m_smp[g][SW-1:0];
        e_stm[g*TWD +: TWD] = m_stm[g][TWD-1:0];
      end
      e_rd = {24'd0, m_tf, |m_pend, 1'b0, |m_trig, m_src, m_mode};
      check(ctl_rdata == e_rd, cur_req, ctl_rdata, e_rd);
      check(trig_req == m_trig, cur_req, trig_req, m_trig);
      check(cont_mode == m_mode && sw_trig_src == m_src, cur_req,
            {cont_mode, sw_trig_src}, {m_mode, m_src});
      check(offset_o == e_ofs, cur_req, offset_o, e_ofs);
      check(factor_o == e_fac, cur_req, factor_o, e_fac);
      check(samples_o == e_smp, cur_req, samples_o, e_smp);
      check(stime_o == e_stm, cur_req, stime_o, e_stm);
    end
  end

  function automatic logic [OW-1:0] ofs(int g, int c); return offset_o[(g*CH+c)*OW +: OW]; endfunction
  function automatic logic [FW-1:0] fac(int g, int c); return factor_o[(g*CH+c)*FW +: FW]; endfunction
  function automatic logic [SW-1:0] smp(int g); return samples_o[g*SW +: SW]; endfunction
  function automatic logic [TWD-1:0] stm(int g); return stime_o[g*TWD +: TWD]; endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctl_wr = 0; ctl_wdata = 0; grp_sel = 0; ch_sel = 0; cfg_value = 0;
    grp_busy = 0; grp_started = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_en = 1;
    @(negedge clk);
    // R1 reset state
    check(ctl_rdata == 0, "R1", ctl_rdata, 0);
    check(smp(0) == 1 && fac(1, 3) == 32 && ofs(0, 0) == 0, "R1", smp(0), 1);
    // R11 mode bits
    cur_req = "R11";
    wr(32'h3);
    check(cont_mode && sw_trig_src && ctl_rdata[1:0] == 2'b11, "R11", ctl_rdata, 3);
    wr(32'h2);
    check(!cont_mode && sw_trig_src, "R11", cont_mode, 0);
    // R2 offset
    cur_req = "R2";
    grp_sel = 32'h1; ch_sel = 32'h5; cfg_value = 32'h1234;
    wr(32'h12);
    @(negedge clk);
    check(ofs(0, 0) == 16'h1234 && ofs(0, 2) == 16'h1234, "R2", ofs(0, 2), 16'h1234);
    check(ofs(0, 1) == 0 && ofs(1, 0) == 0, "R2", ofs(1, 0), 0);
    // R3 factor
    cur_req = "R3";
    grp_sel = 32'h3; ch_sel = 32'h8; cfg_value = 32'h2ABCD;
    wr(32'h30);
    @(negedge clk);
    check(fac(0, 3) == 18'h2ABCD && fac(1, 3) == 18'h2ABCD, "R3", fac(1, 3), 18'h2ABCD);
    check(fac(1, 0) == 32, "R3", fac(1, 0), 32);
    // R4 samples and sample time
    cur_req = "R4";
    grp_sel = 32'h2; ch_sel = 0; cfg_value = 7;
    wr(32'h50);
    @(negedge clk);
    check(smp(1) == 7 && smp(0) == 1, "R4", smp(1), 7);
    grp_sel = 32'h3; cfg_value = 32'h55;
    wr(32'h70);
    @(negedge clk);
    check(stm(0) == 16'h55 && stm(1) == 16'h55, "R4", stm(1), 16'h55);
    // R5 / R6 busy deferral, R8 drop
    cur_req = "R5";
    grp_busy = 2'b10; grp_sel = 32'h3; ch_sel = 32'h2; cfg_value = 32'h77;
    wr(32'h10);
    check(ctl_rdata[4] == 1'b1, "R6", ctl_rdata[4], 1);
    @(negedge clk);
    check(ofs(0, 1) == 16'h77 && ofs(1, 1) == 0, "R5", ofs(1, 1), 0);
    check(ctl_rdata[4] == 1'b1, "R6", ctl_rdata[4], 1);
    cur_req = "R8";
    grp_sel = 32'h1; ch_sel = 32'h1; cfg_value = 32'h99;
    wr(32'h10);
    @(negedge clk);
    check(ofs(0, 0) == 16'h1234, "R8", ofs(0, 0), 16'h1234);
    repeat (3) @(negedge clk);
    check(ofs(1, 1) == 0, "R5", ofs(1, 1), 0);
    grp_busy = 2'b00;
    @(negedge clk);
    check(ofs(1, 1) == 16'h77 && ctl_rdata[4] == 1'b0, "R5", ofs(1, 1), 16'h77);
    @(negedge clk);
    check(ofs(0, 0) == 16'h1234, "R8", ofs(0, 0), 16'h1234);
    // R7 reserved code
    cur_req = "R7";
    grp_sel = 32'h3; ch_sel = 32'hF; cfg_value = 32'hFFFF;
    wr(32'h90);
    check(ctl_rdata[7:5] == 3'd4, "R7", ctl_rdata[7:5], 4);
    @(negedge clk);
    check(ctl_rdata[4] == 0 && ofs(0, 0) == 16'h1234 && smp(1) == 7, "R7", ofs(0, 0), 16'h1234);
    // R6 out-of-range masks only
    cur_req = "R6";
    grp_sel = 32'hFFFF_FFFC; cfg_value = 5;
    wr(32'h10);
    check(ctl_rdata[4] == 0, "R6", ctl_rdata[4], 0);
    @(negedge clk);
    check(ofs(0, 2) == 16'h1234, "R6", ofs(0, 2), 16'h1234);
    // R9 trigger
    cur_req = "R9";
    grp_sel = 32'h2;
    wr(32'h04);
    check(trig_req == 2'b10 && ctl_rdata[2], "R9", trig_req, 2);
    repeat (3) @(negedge clk);
    check(trig_req == 2'b10, "R9", trig_req, 2);
    grp_started = 2'b10;
    @(negedge clk);
    grp_started = 0;
    check(trig_req == 0 && !ctl_rdata[2], "R9", trig_req, 0);
    // R10 software reset
    cur_req = "R10";
    wr(32'h01);
    check(cont_mode == 1'b1, "R11", cont_mode, 1);
    grp_sel = 32'h3; ch_sel = 32'hF; cfg_value = 32'hAAAA;
    wr(32'h19);
    check(cont_mode == 1'b1 && ctl_rdata[4:3] == 2'b00, "R10", ctl_rdata, 1);
    @(negedge clk);
    check(ctl_rdata == 0 && ofs(0, 0) == 0, "R10", ofs(0, 0), 0);
    check(smp(1) == 1 && stm(0) == 0 && fac(0, 3) == 32, "R10", smp(1), 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule